// File: doc/BRIEF.md
# Handshaked Request/Response Register Target

This block is a target port that serves a small bank of word registers over a point-to-point synchronous handshake with two independent phases. A master presents a command, a byte address and, for stores, a data word, and holds them until the target raises its command-accept strobe. Stores finish in the accepting cycle. Loads and unknown commands then open a response phase: the target drives a response code and a data word and holds them until the master raises its response-accept input.

Both phases can be stretched. The target waits a fixed number of cycles, set by parameters, before it accepts a command and before it presents a response. The master can delay taking a response for as long as it needs. Only one transaction is in flight at a time.

The controller is a state machine with five states. ST_IDLE waits for a command. ST_AWAIT counts the accept wait states. ST_ACC raises the accept strobe. ST_RWAIT counts the response wait states. ST_RESP drives the response. These are the transitions:
- *start*: ST_IDLE moves to ST_AWAIT, or straight to ST_ACC when there are no accept wait states.
- *abandon*: ST_AWAIT or ST_ACC returns to ST_IDLE when the command goes back to idle.
- *ready*: ST_AWAIT moves to ST_ACC when its count runs out.
- *store-done*: ST_ACC returns to ST_IDLE after a write.
- *answer*: ST_ACC moves to ST_RWAIT, or to ST_RESP when there are no response wait states.
- *present*: ST_RWAIT moves to ST_RESP when its count runs out.
- *release*: ST_RESP returns to ST_IDLE when the master accepts the response.

Top module: `req_rsp_target`

## Requirements
- R1: After reset, `s_cmd_accept` is 0, `s_resp` is 0 (null) and `s_rdata` is 0, and every register reads back as 0.
- R2: A non-idle command presented from ST_IDLE is accepted exactly ACCEPT_WAIT+1 cycles after it first appears. `s_cmd_accept` is high for a single cycle.
- R3: `s_cmd_accept` is high only while `m_cmd` is non-idle. Command code 0 is idle. A command withdrawn before it is accepted has no effect.
- R4: A write (`m_cmd` = 1) to a valid address stores `m_wdata` in the word at index `m_addr[IDX_W+1:2]` in its accept cycle, and opens no response phase (`s_resp` stays 0). An address is valid when bits [1:0] are zero and it is below DEPTH*4.
- R5: A write to an invalid address (misaligned, or at or above DEPTH*4) is accepted and discarded. No register changes.
- R6: A read (`m_cmd` = 2) of a valid address returns response code 1 with the stored word. The response first appears RESP_WAIT+1 cycles after the accept cycle. Response code 2 never appears.
- R7: A read of an invalid address, or any command code 3 to 7, is accepted and answered with response code 3 and data 0. It changes no register.
- R8: `s_resp` and `s_rdata` stay stable until `m_resp_accept` is sampled high. In the next cycle they return to 0.
- R9: While a response is pending, `s_cmd_accept` stays low whatever the master presents, and a command presented then has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| m_cmd | input | 3 | Command: 0 idle, 1 write, 2 read, others illegal |
| m_addr | input | ADDR_W | Byte address of the request |
| m_wdata | input | DATA_W | Write data |
| s_cmd_accept | output | 1 | Request phase completes when high |
| s_resp | output | 2 | Response code: 0 null, 1 data valid, 3 error |
| s_rdata | output | DATA_W | Response data |
| m_resp_accept | input | 1 | Master takes the response when high |

## Verification
The checker tests handshake rules on every cycle. The accept strobe lasts a single cycle and appears only with a non-idle command. Accept stays low while a response is pending. A write is never followed by a response. A held response does not change, and it is gone one cycle after it is taken. The exact accept and response latencies, the stored and returned data, the discarding of bad writes and error answers, and the harmlessness of commands withdrawn or presented during a stall depend on the register contents and the cycle count. Only the bench scenarios, with their reference model, show these.

// File: rtl/rrt_pkg.sv
package rrt_pkg;
    localparam int CMD_W = 3;
    localparam int RSP_W = 2;

    typedef enum logic [CMD_W-1:0] {
        CMD_IDLE  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_READ  = 3'd2
    } cmd_e;

    typedef enum logic [RSP_W-1:0] {
        RSP_NULL = 2'd0,
        RSP_DATA = 2'd1,
        RSP_ERR  = 2'd3
    } rsp_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_AWAIT,
        ST_ACC,
        ST_RWAIT,
        ST_RESP
    } state_e;
endpackage

// File: rtl/rrt_regfile.sv
module rrt_regfile #(
    parameter int DEPTH  = 16,
    parameter int DATA_W = 32,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] words [DEPTH];

    for (genvar w = 0; w < DEPTH; w++) begin : g_word
        logic [DATA_W-1:0] word_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                word_q <= '0;
            end else if (wr_en && wr_idx == IDX_W'(w)) begin
                word_q <= wr_data;
            end
        end
        assign words[w] = word_q;
    end

    assign rd_data = words[rd_idx];
endmodule

// File: rtl/rrt_wait_cnt.sv
module rrt_wait_cnt #(
    parameter int CNT_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             cnt_zero
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign cnt_zero = (cnt_q == '0);
endmodule

// File: rtl/rrt_ctrl.sv
module rrt_ctrl
    import rrt_pkg::*;
#(
    parameter int DATA_W      = 32,
    parameter int ACCEPT_WAIT = 2,
    parameter int RESP_WAIT   = 1,
    localparam int MAX_WAIT   = (ACCEPT_WAIT > RESP_WAIT) ? ACCEPT_WAIT : RESP_WAIT,
    localparam int CNT_W      = (MAX_WAIT < 2) ? 1 : $clog2(MAX_WAIT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CMD_W-1:0]  cmd,
    input  logic              addr_ok,
    input  logic              resp_accept,
    input  logic [DATA_W-1:0] rd_data,
    output logic              cmd_accept,
    output logic              wr_en,
    output logic [RSP_W-1:0]  resp,
    output logic [DATA_W-1:0] rdata
);
    localparam logic [CNT_W-1:0] ACC_LOAD = (ACCEPT_WAIT > 0) ? CNT_W'(ACCEPT_WAIT - 1) : '0;
    localparam logic [CNT_W-1:0] RSP_LOAD = (RESP_WAIT > 0)   ? CNT_W'(RESP_WAIT - 1)   : '0;

    state_e            state_q, state_n;
    rsp_e              code_q;
    logic [DATA_W-1:0] data_q;
    logic              cnt_load;
    logic [CNT_W-1:0]  cnt_val;
    logic              cnt_zero;
    logic              capture;
    logic              cmd_live;

    assign cmd_live = (cmd != CMD_IDLE);

    rrt_wait_cnt #(.CNT_W(CNT_W)) i_wait (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (cnt_load),
        .load_val (cnt_val),
        .cnt_zero (cnt_zero)
    );

    // State register and captured response
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= RSP_NULL;
            data_q  <= '0;
        end else begin
            state_q <= state_n;
            if (capture) begin
                code_q <= (cmd == CMD_READ && addr_ok) ? RSP_DATA : RSP_ERR;
                data_q <= (cmd == CMD_READ && addr_ok) ? rd_data : '0;
            end
        end
    end

    // Transitions
    always_comb begin
        state_n  = state_q;
        cnt_load = 1'b0;
        cnt_val  = '0;
        capture  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cmd_live) begin
                    if (ACCEPT_WAIT == 0) begin
                        state_n = ST_ACC;
                    end else begin
                        state_n  = ST_AWAIT;
                        cnt_load = 1'b1;
                        cnt_val  = ACC_LOAD;
                    end
                end
            end
            ST_AWAIT: begin
                if (!cmd_live)     state_n = ST_IDLE;
                else if (cnt_zero) state_n = ST_ACC;
            end
            ST_ACC: begin
                if (!cmd_live || cmd == CMD_WRITE) begin
                    state_n = ST_IDLE;
                end else begin
                    capture = 1'b1;
                    if (RESP_WAIT == 0) begin
                        state_n = ST_RESP;
                    end else begin
                        state_n  = ST_RWAIT;
                        cnt_load = 1'b1;
                        cnt_val  = RSP_LOAD;
                    end
                end
            end
            ST_RWAIT: begin
                if (cnt_zero) state_n = ST_RESP;
            end
            ST_RESP: begin
                if (resp_accept) state_n = ST_IDLE;
            end
            default: state_n = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        cmd_accept = (state_q == ST_ACC) && cmd_live;
        wr_en      = cmd_accept && (cmd == CMD_WRITE) && addr_ok;
        resp       = (state_q == ST_RESP) ? code_q : RSP_NULL;
        rdata      = (state_q == ST_RESP) ? data_q : '0;
    end
endmodule

// File: rtl/req_rsp_target.sv
module req_rsp_target
    import rrt_pkg::*;
#(
    parameter int ADDR_W      = 32,
    parameter int DATA_W      = 32,
    parameter int DEPTH       = 16,
    parameter int ACCEPT_WAIT = 2,
    parameter int RESP_WAIT   = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        m_cmd,
    input  logic [ADDR_W-1:0] m_addr,
    input  logic [DATA_W-1:0] m_wdata,
    output logic              s_cmd_accept,
    output logic [1:0]        s_resp,
    output logic [DATA_W-1:0] s_rdata,
    input  logic              m_resp_accept
);
    localparam int IDX_W = $clog2(DEPTH);
    localparam int TOP_B = IDX_W + 2;

    logic [IDX_W-1:0]  idx;
    logic              addr_ok;
    logic              wr_en;
    logic [DATA_W-1:0] rd_data;

    assign idx     = m_addr[TOP_B-1:2];
    assign addr_ok = (m_addr[1:0] == 2'b00) && (m_addr[ADDR_W-1:TOP_B] == '0);

    rrt_regfile #(.DEPTH(DEPTH), .DATA_W(DATA_W)) i_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_idx  (idx),
        .wr_data (m_wdata),
        .rd_idx  (idx),
        .rd_data (rd_data)
    );

    rrt_ctrl #(
        .DATA_W      (DATA_W),
        .ACCEPT_WAIT (ACCEPT_WAIT),
        .RESP_WAIT   (RESP_WAIT)
    ) i_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd         (m_cmd),
        .addr_ok     (addr_ok),
        .resp_accept (m_resp_accept),
        .rd_data     (rd_data),
        .cmd_accept  (s_cmd_accept),
        .wr_en       (wr_en),
        .resp        (s_resp),
        .rdata       (s_rdata)
    );
endmodule

// File: rtl/rrt_checker.sv
module rrt_checker
    import rrt_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [2:0]        m_cmd,
    input logic              s_cmd_accept,
    input logic [1:0]        s_resp,
    input logic [DATA_W-1:0] s_rdata,
    input logic              m_resp_accept
);
    assert_single_accept_R2: assert property (@(posedge clk) disable iff (!rst_n)
        s_cmd_accept |=> !s_cmd_accept);

    assert_accept_needs_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
        s_cmd_accept |-> (m_cmd != CMD_IDLE));

    assert_write_no_resp_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_cmd_accept && m_cmd == CMD_WRITE) |=> (s_resp == RSP_NULL));

    assert_code_legal_R6: assert property (@(posedge clk) disable iff (!rst_n)
        s_resp != 2'd2);

    assert_resp_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp != RSP_NULL && !m_resp_accept) |=> ($stable(s_resp) && $stable(s_rdata)));

    assert_resp_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp != RSP_NULL && m_resp_accept) |=> (s_resp == RSP_NULL && s_rdata == '0));

    assert_one_outstanding_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (s_resp != RSP_NULL) |-> !s_cmd_accept);
endmodule

bind req_rsp_target rrt_checker #(.DATA_W(DATA_W)) i_rrt_checker (
    .clk           (clk),
    .rst_n         (rst_n),
    .m_cmd         (m_cmd),
    .s_cmd_accept  (s_cmd_accept),
    .s_resp        (s_resp),
    .s_rdata       (s_rdata),
    .m_resp_accept (m_resp_accept)
);

// File: tb/test_req_rsp_target.sv
module test_req_rsp_target;
    localparam int AW    = 2;
    localparam int RW    = 1;
    localparam int DEPTH = 16;
    localparam int IDX_W = $clog2(DEPTH);

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  m_cmd = 3'd0;
    logic [31:0] m_addr = '0;
    logic [31:0] m_wdata = '0;
    logic        m_resp_accept = 1'b0;
    logic        s_cmd_accept;
    logic [1:0]  s_resp;
    logic [31:0] s_rdata;

    int total = 0;
    int bad = 0;
    bit finished = 0;
    logic [31:0] model [DEPTH];

    always #2.5 clk = ~clk;

    req_rsp_target #(
        .ADDR_W(32), .DATA_W(32), .DEPTH(DEPTH), .ACCEPT_WAIT(AW), .RESP_WAIT(RW)
    ) i_req_rsp_target (
        .clk(clk), .rst_n(rst_n), .m_cmd(m_cmd), .m_addr(m_addr), .m_wdata(m_wdata),
        .s_cmd_accept(s_cmd_accept), .s_resp(s_resp), .s_rdata(s_rdata),
        .m_resp_accept(m_resp_accept)
    );

    function automatic bit addr_valid(input logic [31:0] a);
        return (a[1:0] == 2'b00) && ((a >> (IDX_W + 2)) == 0);
    endfunction

    function automatic logic [1:0] exp_code(input logic [2:0] c, input logic [31:0] a);
        return (c == 3'd2 && addr_valid(a)) ? 2'd1 : 2'd3;
    endfunction

    function automatic logic [31:0] exp_data(input logic [2:0] c, input logic [31:0] a);
        return (c == 3'd2 && addr_valid(a)) ? model[a[IDX_W+1:2]] : 32'd0;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h at %0t", req, act, exp, $time);
        end
    endtask

    // One complete transaction; stall = cycles the response is left pending
    task automatic run_op(input logic [2:0] c, input logic [31:0] a, input logic [31:0] d,
                          input int stall, input string req);
        int waits;
        int rw;
        logic [1:0]  ec;
        logic [31:0] ed;
        ec = exp_code(c, a);
        ed = exp_data(c, a);
        @(negedge clk);
        m_cmd = c; m_addr = a; m_wdata = d;
        #1;
        waits = 0;
        while (!s_cmd_accept && waits < 50) begin
            waits++;
            @(negedge clk); #1;
        end
        chk(waits == AW + 1, "R2", waits, AW + 1);
        if (c == 3'd1 && addr_valid(a)) model[a[IDX_W+1:2]] = d;
        @(negedge clk);
        m_cmd = 3'd0;
        #1;
        if (c == 3'd1) begin
            chk(s_resp == 2'd0, addr_valid(a) ? "R4" : "R5", s_resp, 0);
            return;
        end
        rw = 0;
        while (s_resp == 2'd0 && rw < 50) begin
            rw++;
            @(negedge clk); #1;
        end
        chk(rw == RW, "R6", rw, RW);
        chk(s_resp == ec, req, s_resp, ec);
        chk(s_rdata == ed, req, s_rdata, ed);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            m_cmd = 3'd1; m_addr = {$urandom % DEPTH, 2'b00}; m_wdata = $urandom;
            #1;
            chk(!s_cmd_accept, "R9", s_cmd_accept, 0);
            chk(s_resp == ec && s_rdata == ed, "R8", s_rdata, ed);
        end
        @(negedge clk);
        m_cmd = 3'd0; m_resp_accept = 1'b1;
        #1;
        chk(s_resp == ec, "R8", s_resp, ec);
        @(negedge clk);
        m_resp_accept = 1'b0;
        #1;
        chk(s_resp == 2'd0 && s_rdata == 32'd0, "R8", s_rdata, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            bad++;
            total++;
            $display("FAIL watchdog R2: actual=timeout expected=completion");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'hC0FFEE));
        for (int i = 0; i < DEPTH; i++) model[i] = '0;
        repeat (3) @(negedge clk);
        #1;
        chk(s_cmd_accept == 1'b0, "R1", s_cmd_accept, 0);
        chk(s_resp == 2'd0, "R1", s_resp, 0);
        chk(s_rdata == 32'd0, "R1", s_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: every register reads zero after reset
        for (int i = 0; i < DEPTH; i++) run_op(3'd2, i * 4, 0, 0, "R1");

        // R3: idle commands are never accepted
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); #1;
            chk(!s_cmd_accept && s_resp == 2'd0, "R3", s_cmd_accept, 0);
        end

        // R3: command withdrawn during accept wait
        @(negedge clk);
        m_cmd = 3'd1; m_addr = 32'h8; m_wdata = 32'hDEAD_BEEF;
        @(negedge clk);
        m_cmd = 3'd0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk); #1;
            chk(!s_cmd_accept, "R3", s_cmd_accept, 0);
        end
        run_op(3'd2, 32'h8, 0, 0, "R3");

        // R4, R6: store and read back, including first and last words
        run_op(3'd1, 32'h0, 32'h1111_2222, 0, "R4");
        run_op(3'd1, (DEPTH - 1) * 4, 32'hA5A5_5A5A, 0, "R4");
        run_op(3'd2, 32'h0, 0, 2, "R6");
        run_op(3'd2, (DEPTH - 1) * 4, 0, 0, "R6");

        // R5: misaligned and out-of-range writes are discarded
        run_op(3'd1, 32'h5, 32'hFFFF_0000, 0, "R5");
        run_op(3'd1, DEPTH * 4, 32'h0BAD_0BAD, 0, "R5");
        run_op(3'd2, 32'h4, 0, 0, "R5");
        run_op(3'd2, 32'h0, 0, 0, "R5");

        // R7: bad reads and illegal command codes
        run_op(3'd2, 32'h2, 0, 1, "R7");
        run_op(3'd2, 32'h8000_0000, 0, 0, "R7");
        run_op(3'd7, 32'h0, 32'h1234_5678, 3, "R7");
        run_op(3'd3, 32'h0, 32'h1234_5678, 0, "R7");
        run_op(3'd2, 32'h0, 0, 0, "R7");

        // R9: long stall with intruding writes, then confirm they did not land
        run_op(3'd2, 32'h4, 0, 6, "R9");
        for (int i = 0; i < DEPTH; i++) run_op(3'd2, i * 4, 0, 0, "R9");

        // Random mix
        for (int n = 0; n < 150; n++) begin
            int sel;
            logic [2:0]  c;
            logic [31:0] a;
            sel = $urandom % 10;
            if (sel < 4)      c = 3'd1;
            else if (sel < 8) c = 3'd2;
            else              c = 3'(3 + $urandom % 5);
            if ($urandom % 8 == 0) a = $urandom;
            else                   a = {$urandom % DEPTH, 2'b00};
            run_op(c, a, $urandom, $urandom % 3, c == 3'd2 ? "R6" : (c == 3'd1 ? "R4" : "R7"));
        end

        finished = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule